// File: doc/BRIEF.md
# Status-Change Interrupt Unit

This block watches two status inputs that come from an analog sensor front end: a single-bit initialization-done flag and a multi-bit IO power-good vector. Whenever either input differs from its value on the previous clock cycle, the block latches a sticky event bit. Each event has an enable bit, and a registered interrupt output is driven from the event and its enable. Software reaches the event, enable and test registers, and a read-only view of the raw inputs, through a plain synchronous register port.

Each input has its own watcher with two states. **SEED** is entered on reset. Its only transition, *seed_to_run*, is taken on the first clock after reset release, and on that same edge the input is captured as the reference value. **RUN** then compares the input with the value captured on the previous edge. Its only transition is *run_hold*, back into itself. The seed state ensures that the value an input holds when reset is released is never reported as a change. Each event bit has three actions: a set from a hardware change or a test write, a write-1-clear from software, and a hold. A set always takes priority over a clear.

Top module: `scu_status_irq`

## Requirements
- R1: After reset, the event register (offset 0x00) and the enable register (offset 0x04) both read 0, and both interrupt outputs are 0.
- R2: A change in any bit of `io_pok_i` sets event bit 0 on the clock edge that samples the new value. This includes a one-bit change and a change in both bits at once.
- R3: A change of `init_done_i`, in either direction, sets event bit 1 on the clock edge that samples the new value.
- R4: The input values present when reset is released do not raise an event, even when they are nonzero.
- R5: A write to offset 0x00 clears each event bit whose write-data bit is 1. Bits written with 0 keep their value.
- R6: If a hardware set and a clear of the same event bit occur on the same edge, the bit ends up set.
- R7: Writing 1 to a bit of the test register (offset 0x08) sets the matching event bit (bit 0 for IO, bit 1 for init). Reads of offset 0x08 return 0.
- R8: The enable register holds bit 0 (IO) and bit 1 (init) as read/write bits. All of its other bits read 0.
- R9: `irq_io_o` and `irq_init_o` each equal the AND of the event bit and the enable bit as registered on the previous edge, so each output lags the event register by one cycle.
- R10: Offset 0x50 returns `init_done_i` in bit 0 and `io_pok_i` in bits 2:1. Its other bits are 0.
- R11: Read data is registered. It is valid in the cycle after `reg_re` is sampled high. Unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 7 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| init_done_i | input | 1 | Initialization-done flag from the sensor front end |
| io_pok_i | input | 2 | IO power-good vector from the sensor front end |
| irq_io_o | output | 1 | Interrupt for an IO power-good change |
| irq_init_o | output | 1 | Interrupt for an init-done change |

## Verification
The checker tests five properties on every cycle:
- A sampled change of the IO vector in the RUN state sets event bit 0.
- Any set of an event bit leaves that bit high, even when a clear arrives on the same edge.
- A clear write with no set pending drops the bit.
- Test-register reads return zero.
- Each interrupt output tracks the previous cycle's event-and-enable product.

Some behaviours can only be shown by the bench's directed scenarios:
- Nonzero inputs at reset release must not raise an event.
- Bits written with 0 must stay untouched.
- Reserved enable bits and unmapped offsets must read zero.
- The status readback must present the bits in the right positions.

// File: rtl/scu_pkg.sv
package scu_pkg;
    localparam int SCU_ADDR_W  = 7;
    localparam int SCU_DATA_W  = 32;
    localparam int SCU_POK_W   = 2;
    localparam int SCU_NUM_EVT = 2;
    localparam int EVT_IO      = 0;
    localparam int EVT_INIT    = 1;

    localparam logic [SCU_ADDR_W-1:0] OFS_EVENT  = 7'h00;
    localparam logic [SCU_ADDR_W-1:0] OFS_ENABLE = 7'h04;
    localparam logic [SCU_ADDR_W-1:0] OFS_TEST   = 7'h08;
    localparam logic [SCU_ADDR_W-1:0] OFS_STATUS = 7'h50;

    typedef enum logic {
        WATCH_SEED = 1'b0,
        WATCH_RUN  = 1'b1
    } watch_state_e;
endpackage

// File: rtl/scu_change_det.sv
module scu_change_det
    import scu_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic         chg_o,
    output logic         armed_o
);
    watch_state_e state_q, state_d;
    logic [W-1:0] ref_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WATCH_SEED: state_d = WATCH_RUN;
            WATCH_RUN:  state_d = WATCH_RUN;
            default:    state_d = WATCH_SEED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WATCH_SEED;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            ref_q   <= sig_i;
        end
    end

    always_comb begin
        armed_o = (state_q == WATCH_RUN);
        chg_o   = armed_o && (sig_i != ref_q);
    end
endmodule

// File: rtl/scu_evt_bit.sv
module scu_evt_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_we_i,
    input  logic en_wdata_i,
    output logic state_o,
    output logic en_o,
    output logic irq_o
);
    logic state_d;

    always_comb begin
        if (set_i)      state_d = 1'b1;
        else if (clr_i) state_d = 1'b0;
        else            state_d = state_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_o <= 1'b0;
            en_o    <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            state_o <= state_d;
            if (en_we_i) en_o <= en_wdata_i;
            irq_o   <= state_o & en_o;
        end
    end
endmodule

// File: rtl/scu_regs.sv
module scu_regs
    import scu_pkg::*;
#(
    parameter int ADDR_W  = SCU_ADDR_W,
    parameter int DATA_W  = SCU_DATA_W,
    parameter int POK_W   = SCU_POK_W,
    parameter int NUM_EVT = SCU_NUM_EVT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_we,
    input  logic               reg_re,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_EVT-1:0] evt_state_i,
    input  logic [NUM_EVT-1:0] evt_en_i,
    input  logic               init_done_i,
    input  logic [POK_W-1:0]   io_pok_i,
    output logic [NUM_EVT-1:0] clr_o,
    output logic [NUM_EVT-1:0] test_o,
    output logic               en_we_o,
    output logic [NUM_EVT-1:0] en_wdata_o
);
    localparam int STAT_W = 1 + POK_W;

    logic              hit_event, hit_enable, hit_test, hit_status;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    always_comb begin
        hit_event  = (reg_addr == ADDR_W'(OFS_EVENT));
        hit_enable = (reg_addr == ADDR_W'(OFS_ENABLE));
        hit_test   = (reg_addr == ADDR_W'(OFS_TEST));
        hit_status = (reg_addr == ADDR_W'(OFS_STATUS));
        clr_o      = (reg_we && hit_event) ? reg_wdata[NUM_EVT-1:0] : '0;
        test_o     = (reg_we && hit_test)  ? reg_wdata[NUM_EVT-1:0] : '0;
        en_we_o    = reg_we && hit_enable;
        en_wdata_o = reg_wdata[NUM_EVT-1:0];
    end

    assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_EVT];

    always_comb begin
        rd_mux = '0;
        if (hit_event)       rd_mux[NUM_EVT-1:0] = evt_state_i;
        else if (hit_enable) rd_mux[NUM_EVT-1:0] = evt_en_i;
        else if (hit_status) rd_mux[STAT_W-1:0]  = {io_pok_i, init_done_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/scu_status_irq.sv
module scu_status_irq
    import scu_pkg::*;
#(
    parameter int ADDR_W = SCU_ADDR_W,
    parameter int DATA_W = SCU_DATA_W,
    parameter int POK_W  = SCU_POK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              init_done_i,
    input  logic [POK_W-1:0]  io_pok_i,
    output logic              irq_io_o,
    output logic              irq_init_o
);
    localparam int NEVT = SCU_NUM_EVT;

    logic [NEVT-1:0] hw_chg, sw_test, sw_clr, evt_set, evt_state, evt_en, evt_irq, en_wdata;
    logic            en_we, io_armed, unused_init_armed;

    scu_change_det #(.W(POK_W)) u_io_det (
        .clk(clk), .rst_n(rst_n), .sig_i(io_pok_i),
        .chg_o(hw_chg[EVT_IO]), .armed_o(io_armed)
    );

    scu_change_det #(.W(1)) u_init_det (
        .clk(clk), .rst_n(rst_n), .sig_i(init_done_i),
        .chg_o(hw_chg[EVT_INIT]), .armed_o(unused_init_armed)
    );

    scu_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POK_W(POK_W), .NUM_EVT(NEVT)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .evt_state_i(evt_state), .evt_en_i(evt_en),
        .init_done_i(init_done_i), .io_pok_i(io_pok_i),
        .clr_o(sw_clr), .test_o(sw_test), .en_we_o(en_we), .en_wdata_o(en_wdata)
    );

    assign evt_set = hw_chg | sw_test;

    for (genvar g = 0; g < NEVT; g++) begin : g_evt
        scu_evt_bit u_bit (
            .clk(clk), .rst_n(rst_n),
            .set_i(evt_set[g]), .clr_i(sw_clr[g]),
            .en_we_i(en_we), .en_wdata_i(en_wdata[g]),
            .state_o(evt_state[g]), .en_o(evt_en[g]), .irq_o(evt_irq[g])
        );
    end

    assign irq_io_o   = evt_irq[EVT_IO];
    assign irq_init_o = evt_irq[EVT_INIT];
endmodule

// File: rtl/scu_status_irq_chk.sv
module scu_status_irq_chk
    import scu_pkg::*;
#(
    parameter int ADDR_W = SCU_ADDR_W,
    parameter int DATA_W = SCU_DATA_W,
    parameter int POK_W  = SCU_POK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic              reg_re,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [POK_W-1:0]  io_pok_i,
    input logic              irq_io_o,
    input logic              irq_init_o,
    input logic              io_armed,
    input logic [1:0]        evt_set,
    input logic [1:0]        evt_state,
    input logic [1:0]        evt_en
);
    p_io_change_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_armed && io_pok_i != $past(io_pok_i)) |=> evt_state[EVT_IO]);

    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFS_EVENT) && reg_wdata[EVT_INIT] && !evt_set[EVT_INIT])
        |=> !evt_state[EVT_INIT]);

    p_set_wins_io_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[EVT_IO] |=> evt_state[EVT_IO]);

    p_set_wins_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_set[EVT_INIT] |=> evt_state[EVT_INIT]);

    p_test_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == ADDR_W'(OFS_TEST)) |=> (reg_rdata == '0));

    p_irq_io_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_io_o == $past(evt_state[EVT_IO] & evt_en[EVT_IO]));

    p_irq_init_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_init_o == $past(evt_state[EVT_INIT] & evt_en[EVT_INIT]));
endmodule

bind scu_status_irq scu_status_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POK_W(POK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .io_pok_i(io_pok_i),
    .irq_io_o(irq_io_o), .irq_init_o(irq_init_o), .io_armed(io_armed),
    .evt_set(evt_set), .evt_state(evt_state), .evt_en(evt_en)
);

// File: tb/scu_status_irq_bench.sv
module scu_status_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        init_done_i = 1'b1;
    logic [1:0]  io_pok_i = 2'b11;
    logic        irq_io_o, irq_init_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scu_status_irq u_scu_status_irq (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .init_done_i(init_done_i), .io_pok_i(io_pok_i),
        .irq_io_o(irq_io_o), .irq_init_o(irq_init_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a; reg_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = reg_rdata;
        reg_re = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(7'h00, v); check("R1/R4 event after reset", v, 0);
        rd(7'h04, v); check("R1 enable after reset", v, 0);
        check("R1 irq after reset", {30'd0, irq_init_o, irq_io_o}, 0);
        rd(7'h50, v); check("R10 status readback", v, 32'h7);
    endtask

    task automatic t_io_change();
        logic [31:0] v;
        io_pok_i = 2'b10;
        @(negedge clk);
        rd(7'h00, v); check("R2 one-bit io change", v, 1);
        wr(7'h00, 32'h1);
        rd(7'h00, v); check("R5 clear io", v, 0);
        io_pok_i = 2'b01;
        @(negedge clk);
        rd(7'h00, v); check("R2 two-bit io change", v, 1);
        rd(7'h50, v); check("R10 status pok=01 init=1", v, 32'h3);
        wr(7'h00, 32'h1);
    endtask

    task automatic t_init_change();
        logic [31:0] v;
        init_done_i = 1'b0;
        @(negedge clk);
        rd(7'h00, v); check("R3 init change", v, 2);
        wr(7'h00, 32'h0);
        rd(7'h00, v); check("R5 zero write keeps", v, 2);
        wr(7'h00, 32'h2);
        rd(7'h00, v); check("R5 clear init", v, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        io_pok_i = 2'b00;
        reg_addr = 7'h00; reg_wdata = 32'h1; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        rd(7'h00, v); check("R6 set beats clear", v, 1);
        wr(7'h00, 32'h1);
    endtask

    task automatic t_test_reg();
        logic [31:0] v;
        wr(7'h08, 32'h3);
        rd(7'h00, v); check("R7 test sets both", v, 3);
        rd(7'h08, v); check("R7 test reads zero", v, 0);
        wr(7'h00, 32'h3);
        rd(7'h00, v); check("R7 cleared after test", v, 0);
    endtask

    task automatic t_enable_irq();
        logic [31:0] v;
        wr(7'h04, 32'hFFFF_FFFF);
        rd(7'h04, v); check("R8 enable reserved bits zero", v, 3);
        check("R9 no irq with no event", {30'd0, irq_init_o, irq_io_o}, 0);
        wr(7'h08, 32'h1);
        check("R9 irq lags event by a cycle", {31'd0, irq_io_o}, 0);
        @(negedge clk);
        check("R9 irq_io asserted", {31'd0, irq_io_o}, 1);
        check("R9 irq_init idle", {31'd0, irq_init_o}, 0);
        wr(7'h04, 32'h2);
        check("R9 irq_io still high one cycle", {31'd0, irq_io_o}, 1);
        @(negedge clk);
        check("R9 irq_io masked", {31'd0, irq_io_o}, 0);
        wr(7'h00, 32'h1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(7'h0C, v); check("R11 unmapped reads zero", v, 0);
        rd(7'h04, v); check("R11 registered read of enable", v, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_io_change();
        t_init_change();
        t_set_wins();
        t_test_reg();
        t_enable_irq();
        t_unmapped();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule